// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block models a synchronous SRAM whose reads are pipelined. The array is organised as words of four byte lanes, each lane 9 bits wide (8 data bits and one parity bit). The depth is `2**AddrW` words. The full 64K-word organisation uses `AddrW = 16`. The default is smaller so that the array elaborates cheaply. The address, chip selects, write controls and write data are all registered on the rising clock edge. A write then lands in the array on the following edge. Read data leaves through an output register. The burst address is produced outside the block, so this core sees only a plain word address each cycle.

A cycle is selected only when all three synchronous chip selects are active. A selected cycle with no write request is a read. Writes go lane by lane under active-low lane enables, and an active-low write-all input overrides them. The shared data bus is split at the core boundary into `dqIn`, `dqOut` and the driver enable `dqDrv`, and the chip-level pad joins them into one bidirectional bus. `dqDrv` follows the asynchronous output enable. It is forced low on the first read after a deselected cycle, so that a newly selected bank does not fight the bank that was just released. It is also forced low while a write sits in the input register.

Top module: `sram_pipe_top`

## Requirements
- R1: A read presented before edge N places the stored word on `dqOut` and can raise `dqDrv` only after edge N+1. Between edges N and N+1, `dqDrv` is 0.
- R2: In a selected cycle with `wrAllN`=1, lane n (bits [9n+8:9n]) is written only when `laneWrN[n]`=0. Lanes whose enable is 1 keep their old contents.
- R3: In a selected cycle with `wrAllN`=0, all four lanes are written whatever the value of `laneWrN`. A selected cycle with `wrAllN`=1 and `laneWrN`=4'b1111 is a read and writes nothing.
- R4: A cycle is selected only when `chipSelN0`=0, `chipSel1`=1 and `chipSelN2`=0. An unselected cycle writes nothing, and its output slot has `dqDrv`=0.
- R5: `outEnN` acts asynchronously. With valid read data held, `dqDrv` follows `!outEnN` with no clock edge.
- R6: A read whose previous cycle was unselected, or which comes first after reset, has its output slot masked (`dqDrv`=0). A read that directly follows a selected cycle is not masked.
- R7: While the cycle held in the input register is a write, `dqDrv` is 0 whatever `outEnN` is.
- R8: While `rstN` is low, `dqDrv` is 0.
- R9: A read presented in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | AddrW | Word address, registered each edge |
| chipSelN0 | input | 1 | Chip select, active low |
| chipSel1 | input | 1 | Chip select, active high |
| chipSelN2 | input | 1 | Chip select, active low |
| wrAllN | input | 1 | Write-all override, active low |
| laneWrN | input | 4 | Per-lane write enables, active low; bit n covers bits [9n+8:9n] |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dqIn | input | 4*LaneW | Write data from the bus pad |
| dqOut | output | 4*LaneW | Registered read data to the bus pad |
| dqDrv | output | 1 | Pad driver enable for `dqOut` |

## Verification
The bench targets the cycle-exact read latency. A design with one pipeline register too few or too many would either show data one edge early or drive the bus late. It targets the masked first read after a deselect, which a careless design would drive straight away and so cause bus contention between banks. It also checks that a pending write hides the drivers even with output enable low.

The bench checks the lane decoding and the write-all override with patterns that differ in every lane, so a swapped or ignored lane shows up in the read-back word. Writes under each of the three broken chip-select conditions must leave memory untouched. A read straight after a write must return the fresh word and not stale array contents.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  localparam int LANE_CNT = 4;

  typedef struct packed {
    logic [LANE_CNT-1:0] laneWe;  // lanes written at this edge
    logic                outLoad; // output register captures array word
  } sramStrobeT;
endpackage

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
  import sram_pipe_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipSelN0,
  input  logic                chipSel1,
  input  logic                chipSelN2,
  input  logic                wrAllN,
  input  logic [LANE_CNT-1:0] laneWrN,
  input  logic                outEnN,
  output sramStrobeT          strobe,
  output logic                dqDrv
);
  logic                selNow;
  logic                wrNow;
  logic [LANE_CNT-1:0] lanesNow;

  logic                selQ;
  logic                wrQ;
  logic [LANE_CNT-1:0] lanesQ;
  logic                prevSelQ;
  logic                outValid;
  logic                outMask;
  logic                wrPending;

  always_comb begin
    selNow   = !chipSelN0 && chipSel1 && !chipSelN2;
    wrNow    = !wrAllN || (laneWrN != '1);
    lanesNow = wrAllN ? ~laneWrN : '1;
  end

  // input stage plus output-slot tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ     <= 1'b0;
      wrQ      <= 1'b0;
      lanesQ   <= '0;
      prevSelQ <= 1'b0;
      outValid <= 1'b0;
      outMask  <= 1'b1;
    end else begin
      selQ     <= selNow;
      wrQ      <= wrNow;
      lanesQ   <= lanesNow;
      prevSelQ <= selQ;
      outValid <= selQ && !wrQ;
      outMask  <= !prevSelQ;
    end
  end

  always_comb begin
    wrPending      = selQ && wrQ;
    strobe.laneWe  = wrPending ? lanesQ : '0;
    strobe.outLoad = selQ && !wrQ;
    dqDrv          = !outEnN && outValid && !outMask && !wrPending;
  end

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !selNow |=> (strobe.laneWe == '0)); // R4

  AST_WRALL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && !wrAllN) |=> (strobe.laneWe == '1)); // R3

  AST_READ_REACHES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && !wrNow) |-> ##2 outValid); // R1

  AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!selNow ##1 (selNow && !wrNow)) |-> ##2 !dqDrv); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> !dqDrv); // R8
endmodule

// File: rtl/sram_pipe_data.sv
module sram_pipe_data
  import sram_pipe_pkg::*;
#(
  parameter int AddrW = 10,
  parameter int LaneW = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [AddrW-1:0]          addr,
  input  logic [LaneW*LANE_CNT-1:0] dqIn,
  input  sramStrobeT                strobe,
  output logic [LaneW*LANE_CNT-1:0] dqOut
);
  localparam int Depth = 1 << AddrW;
  localparam int DataW = LaneW * LANE_CNT;

  logic [AddrW-1:0] addrQ;
  logic [DataW-1:0] dinQ;
  logic [DataW-1:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dinQ  <= '0;
    end else begin
      addrQ <= addr;
      dinQ  <= dqIn;
    end
  end

  // one storage array per byte lane, written independently
  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    logic [LaneW-1:0] laneMem [Depth];

    always_ff @(posedge clk) begin
      if (strobe.laneWe[g]) laneMem[addrQ] <= dinQ[g*LaneW +: LaneW];
    end

    assign rdWord[g*LaneW +: LaneW] = laneMem[addrQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dqOut <= '0;
    else if (strobe.outLoad) dqOut <= rdWord;
  end

  AST_LOAD_NOT_DURING_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.outLoad && (strobe.laneWe != '0))); // R7
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
  import sram_pipe_pkg::*;
#(
  parameter int AddrW = 10,
  parameter int LaneW = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [AddrW-1:0]          addr,
  input  logic                      chipSelN0,
  input  logic                      chipSel1,
  input  logic                      chipSelN2,
  input  logic                      wrAllN,
  input  logic [LANE_CNT-1:0]       laneWrN,
  input  logic                      outEnN,
  input  logic [LaneW*LANE_CNT-1:0] dqIn,
  output logic [LaneW*LANE_CNT-1:0] dqOut,
  output logic                      dqDrv
);
  sramStrobeT strobe;

  sram_pipe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipSelN0 (chipSelN0),
    .chipSel1  (chipSel1),
    .chipSelN2 (chipSelN2),
    .wrAllN    (wrAllN),
    .laneWrN   (laneWrN),
    .outEnN    (outEnN),
    .strobe    (strobe),
    .dqDrv     (dqDrv)
  );

  sram_pipe_data #(.AddrW(AddrW), .LaneW(LaneW)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .dqIn   (dqIn),
    .strobe (strobe),
    .dqOut  (dqOut)
  );

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.laneWe != '0) |-> !dqDrv); // R7
endmodule

// File: tb/sim_sram_pipe_top.sv
module sim_sram_pipe_top;
  localparam int AW = 10;
  localparam int LW = 9;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          chipSelN0 = 1'b1;
  logic          chipSel1 = 1'b1;
  logic          chipSelN2 = 1'b0;
  logic          wrAllN = 1'b1;
  logic [3:0]    laneWrN = 4'hF;
  logic          outEnN = 1'b0;
  logic [DW-1:0] dqIn = '0;
  logic [DW-1:0] dqOut;
  logic          dqDrv;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_pipe_top #(.AddrW(AW), .LaneW(LW)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .chipSelN0(chipSelN0),
    .chipSel1(chipSel1), .chipSelN2(chipSelN2), .wrAllN(wrAllN),
    .laneWrN(laneWrN), .outEnN(outEnN), .dqIn(dqIn), .dqOut(dqOut),
    .dqDrv(dqDrv)
  );

  task automatic chkVal(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setIn(bit sel, bit g, logic [3:0] b, logic [AW-1:0] a, logic [DW-1:0] d);
    chipSelN0 = !sel; chipSel1 = 1'b1; chipSelN2 = 1'b0;
    wrAllN = g; laneWrN = b; addr = a; dqIn = d;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, bit g, logic [3:0] b);
    setIn(1'b1, g, b, a, d);
    tick();
  endtask

  // caller ensures the previous cycle was selected
  task automatic readBack(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    setIn(1'b1, 1'b1, 4'hF, a, '0);
    tick();
    tick();
    chkVal(req, {35'd0, dqDrv}, 36'd1);
    chkVal(req, dqOut, exp);
  endtask

  task automatic tReset();
    setIn(1'b1, 1'b1, 4'hF, 10'h001, '0);
    repeat (3) tick();
    chkVal("R8 drv in reset", {35'd0, dqDrv}, 36'd0);
    setIn(1'b0, 1'b1, 4'hF, '0, '0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic tLatency();
    wr(10'h010, 36'h9_A5C3_1E7F, 1'b0, 4'hF);
    setIn(1'b1, 1'b1, 4'hF, 10'h010, '0);
    tick();
    chkVal("R1 no drive one edge after read", {35'd0, dqDrv}, 36'd0);
    tick();
    chkVal("R1 drive two edges after read", {35'd0, dqDrv}, 36'd1);
    chkVal("R9 read right after write", dqOut, 36'h9_A5C3_1E7F);
  endtask

  task automatic tLanes();
    wr(10'h020, 36'h0, 1'b0, 4'hF);
    wr(10'h020, 36'hF_FFFF_FFFF, 1'b1, 4'b1010);
    readBack(10'h020, {9'h000, 9'h1FF, 9'h000, 9'h1FF}, "R2 lanes 0,2");
    wr(10'h020, 36'h0, 1'b1, 4'b0111);
    readBack(10'h020, {9'h000, 9'h1FF, 9'h000, 9'h1FF}, "R2 lane 3 cleared only");
  endtask

  task automatic tWrAll();
    wr(10'h030, 36'h0, 1'b0, 4'hF);
    wr(10'h030, 36'h5_1234_ABCD, 1'b0, 4'hF);
    readBack(10'h030, 36'h5_1234_ABCD, "R3 write-all override");
    setIn(1'b1, 1'b1, 4'hF, 10'h030, 36'hA_EDCB_5432);
    tick();
    readBack(10'h030, 36'h5_1234_ABCD, "R3 no write without enables");
  endtask

  task automatic tDeselect();
    wr(10'h040, 36'h3_C3C3_C3C3, 1'b0, 4'hF);
    for (int k = 0; k < 3; k++) begin
      setIn(1'b1, 1'b0, 4'h0, 10'h040, 36'hE_0F0F_0F0F);
      if (k == 0) chipSelN0 = 1'b1;
      if (k == 1) chipSel1 = 1'b0;
      if (k == 2) chipSelN2 = 1'b1;
      tick();
    end
    chkVal("R4 no drive after deselect", {35'd0, dqDrv}, 36'd0);
    setIn(1'b1, 1'b1, 4'hF, 10'h040, '0);
    tick();
    readBack(10'h040, 36'h3_C3C3_C3C3, "R4 deselected writes ignored");
  endtask

  task automatic tMask();
    wr(10'h050, 36'h7_0101_8080, 1'b0, 4'hF);
    setIn(1'b0, 1'b1, 4'hF, '0, '0);
    tick();
    setIn(1'b1, 1'b1, 4'hF, 10'h050, '0);
    tick();
    tick();
    chkVal("R6 first read masked", {35'd0, dqDrv}, 36'd0);
    tick();
    chkVal("R6 second read driven", {35'd0, dqDrv}, 36'd1);
    chkVal("R6 second read data", dqOut, 36'h7_0101_8080);
  endtask

  task automatic tOutEn();
    readBack(10'h050, 36'h7_0101_8080, "R5 setup");
    outEnN = 1'b1;
    #1;
    chkVal("R5 async disable", {35'd0, dqDrv}, 36'd0);
    outEnN = 1'b0;
    #1;
    chkVal("R5 async enable", {35'd0, dqDrv}, 36'd1);
  endtask

  task automatic tWriteHides();
    readBack(10'h030, 36'h5_1234_ABCD, "R7 setup");
    wr(10'h060, 36'h1_1111_1111, 1'b0, 4'hF);
    chkVal("R7 no drive during write", {35'd0, dqDrv}, 36'd0);
    readBack(10'h060, 36'h1_1111_1111, "R7 write landed");
  endtask

  initial begin
    tReset();
    tLatency();
    tLanes();
    tWrAll();
    tDeselect();
    tMask();
    tOutEn();
    tWriteHides();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule